// File: doc/BRIEF.md
# Self-Timed Non-Volatile Memory Tick Prescaler

This block produces the steady timing tick that a program/erase sequencer for on-chip non-volatile memory uses to time its pulses. A modulus counter advances once per source-clock cycle and emits a one-cycle tick each time it completes a period of (divisor + 1) source cycles. Each source clock reaches the block as a strobe in the system clock domain, one strobe per source cycle. In normal operation the crystal strobe drives the count and a 10-bit divisor comes from two byte-wide registers.

When the limp-home indication is raised, the block stops using the crystal. It counts PLL strobes instead, with a fixed divisor of 0x023, and it ignores the programmed registers for timing. Each change of mode restarts the count from zero. Entering limp-home also gives a one-cycle abort pulse, so that the sequencer can drop its program and latch enables. After reset the divisor registers hold the value of a shadow input word. Software can later rewrite them one byte at a time, and a new value applies from the next period boundary.

Top module: `nvm_tick_gen`

## Requirements
- R1: Register address 0 (upper byte) holds divisor bits 9:8 in its bits 1:0. A write there stores only wdata bits 1:0, and a read always returns zeros in bits 7:2.
- R2: Register address 1 (lower byte) holds divisor bits 7:0. A read returns the stored byte on reg_rdata, registered, one clock after reg_sel is applied.
- R3: While rst is high, the divisor registers load the shadow_div input. After rst is released, ticks use that value until software writes new bytes.
- R4: In normal mode (limp low), tick is a one-cycle pulse. It comes once every (divisor + 1) cycles in which xtal_stb is high.
- R5: In limp-home mode (limp high), ticks come every 0x023 + 1 = 36 pll_stb cycles, whatever the registers hold. The registers can still be written and read in this mode.
- R6: A divisor write does not shorten the period in progress. The new value takes effect at the next terminal count.
- R7: A rising edge of limp produces exactly one abort pulse, one cycle wide and registered. A falling edge of limp produces none.
- R8: A change of limp in either direction clears the counter to zero on the next clock. The first tick of the new mode comes after a full period of the new source and divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shadow_div | input | 10 | Divisor value loaded into the registers during reset |
| xtal_stb | input | 1 | One pulse per crystal-derived source cycle |
| pll_stb | input | 1 | One pulse per PLL-derived source cycle |
| limp | input | 1 | Limp-home indication (crystal lost) |
| reg_we | input | 1 | Byte write strobe |
| reg_sel | input | 1 | Register select: 0 upper byte, 1 lower byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| tick | output | 1 | One-cycle timing tick |
| abort | output | 1 | One-cycle pulse on entry to limp-home mode |

## Verification
The bench builds the block with its default parameters: a 10-bit divisor split into an 8-bit lower byte and a 2-bit upper byte, and a fixed fallback divisor of 0x023. With these values the full range can be tested. This covers divisor 0, where a tick follows every strobe, divisor 0x3FF with a 1024-strobe period, and crystal strobes spaced several system cycles apart. The fixed fallback divisor is small, so the exact latency of the restart on entering and leaving limp-home can be measured over a few dozen cycles.

// File: rtl/nvm_tick_pkg.sv
package nvm_tick_pkg;
  // Register select codes (byte address of the divisor halves)
  localparam logic ADDR_HI = 1'b0;
  localparam logic ADDR_LO = 1'b1;

  typedef enum logic {
    SRC_XTAL = 1'b0,
    SRC_PLL  = 1'b1
  } src_e;
endpackage

// File: rtl/nvm_div_regs.sv
module nvm_div_regs
  import nvm_tick_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  shadow_div,
  input  logic              we,
  input  logic              sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_q
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [BYTE_W-1:0] hi_view;
  logic              unused_wdata_hi;

  // Upper byte view: divisor top bits right-aligned, rest zero-padded
  assign hi_view         = BYTE_W'(div_q[DIV_W-1:BYTE_W]);
  assign unused_wdata_hi = ^wdata[BYTE_W-1:HI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= shadow_div;
      rdata <= '0;
    end else begin
      if (we) begin
        if (sel == ADDR_HI) div_q[DIV_W-1:BYTE_W] <= wdata[HI_W-1:0];
        else                div_q[BYTE_W-1:0]     <= wdata;
      end
      rdata <= (sel == ADDR_HI) ? hi_view : div_q[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/nvm_src_sel.sv
module nvm_src_sel
  import nvm_tick_pkg::*;
#(
  parameter int                DIV_W    = 10,
  parameter logic [DIV_W-1:0]  LIMP_DIV = 10'h023
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             limp,
  input  logic             xtal_stb,
  input  logic             pll_stb,
  input  logic [DIV_W-1:0] prog_div,
  output logic             step,
  output logic             restart,
  output logic [DIV_W-1:0] next_div,
  output logic             abort
);
  src_e src_q;
  src_e src_d;

  assign src_d    = limp ? SRC_PLL : SRC_XTAL;
  assign restart  = (src_d != src_q);
  assign step     = (src_q == SRC_PLL) ? pll_stb : xtal_stb;
  // Divisor of the mode in force after this edge
  assign next_div = (src_d == SRC_PLL) ? LIMP_DIV : prog_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_XTAL;
      abort <= 1'b0;
    end else begin
      src_q <= src_d;
      abort <= (src_d == SRC_PLL) && (src_q == SRC_XTAL);
    end
  end
endmodule

// File: rtl/nvm_mod_counter.sv
module nvm_mod_counter #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             restart,
  input  logic [DIV_W-1:0] next_div,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] act_div,
  output logic             tick
);
  logic at_end;
  assign at_end = (cnt == act_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_div <= next_div;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (restart) begin
        cnt     <= '0;
        act_div <= next_div;
      end else if (step) begin
        if (at_end) begin
          cnt     <= '0;
          act_div <= next_div;
          tick    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
  parameter int                DIV_W    = 10,
  parameter int                BYTE_W   = 8,
  parameter logic [DIV_W-1:0]  LIMP_DIV = 10'h023
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  shadow_div,
  input  logic              xtal_stb,
  input  logic              pll_stb,
  input  logic              limp,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              tick,
  output logic              abort
);
  logic [DIV_W-1:0] prog_div;
  logic [DIV_W-1:0] next_div;
  logic [DIV_W-1:0] cnt_w;
  logic [DIV_W-1:0] act_div_w;
  logic             step_w;
  logic             restart_w;

  nvm_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .shadow_div(shadow_div),
    .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .div_q(prog_div)
  );

  nvm_src_sel #(.DIV_W(DIV_W), .LIMP_DIV(LIMP_DIV)) u_src (
    .clk(clk), .rst(rst), .limp(limp),
    .xtal_stb(xtal_stb), .pll_stb(pll_stb), .prog_div(prog_div),
    .step(step_w), .restart(restart_w), .next_div(next_div), .abort(abort)
  );

  nvm_mod_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step_w), .restart(restart_w),
    .next_div(next_div), .cnt(cnt_w), .act_div(act_div_w), .tick(tick)
  );
endmodule

// File: rtl/nvm_tick_chk.sv
module nvm_tick_chk #(
  parameter int                DIV_W    = 10,
  parameter int                BYTE_W   = 8,
  parameter logic [DIV_W-1:0]  LIMP_DIV = 10'h023
) (
  input logic              clk,
  input logic              rst,
  input logic              limp,
  input logic              reg_sel,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              tick,
  input logic              abort,
  input logic              step,
  input logic              restart,
  input logic [DIV_W-1:0]  cnt,
  input logic [DIV_W-1:0]  act_div
);
  localparam int HI_W = DIV_W - BYTE_W;

  p_hi_pad_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_sel) == 1'b0) |-> (reg_rdata[BYTE_W-1:HI_W] == '0));

  p_tick_after_step_r4: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(step) && !$past(restart)));

  p_limp_divisor_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && $past(limp)) |-> (act_div == LIMP_DIV));

  p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= act_div);

  p_abort_single_r7: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);

  p_abort_on_entry_r7: assert property (@(posedge clk) disable iff (rst)
    abort |-> $past(limp));

  p_restart_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (cnt == '0 && !tick));
endmodule

bind nvm_tick_gen nvm_tick_chk #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .LIMP_DIV(LIMP_DIV)) u_chk (
  .clk(clk), .rst(rst), .limp(limp), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .tick(tick), .abort(abort), .step(step_w), .restart(restart_w),
  .cnt(cnt_w), .act_div(act_div_w)
);

// File: tb/test_nvm_tick_gen.sv
`timescale 1ns/1ps
module test_nvm_tick_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] shadow_div = 10'h12C;
  logic       xtal_stb = 1'b1;
  logic       pll_stb = 1'b1;
  logic       limp = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tick;
  logic       abort;

  int checks = 0;
  int errors = 0;
  int xp = 1;
  int phase = 0;
  int cyc = 0;
  int last_tick = 0;
  int gap = 0;
  int ntick = 0;
  int naborts = 0;

  // divisor, crystal strobe spacing, expected tick spacing in cycles
  localparam int VEC[6][3] = '{
    '{3,    1, 4},
    '{0,    1, 1},
    '{9,    2, 20},
    '{1023, 1, 1024},
    '{5,    3, 18},
    '{256,  1, 257}
  };

  nvm_tick_gen i_nvm_tick_gen (
    .clk(clk), .rst(rst), .shadow_div(shadow_div),
    .xtal_stb(xtal_stb), .pll_stb(pll_stb), .limp(limp),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick(tick), .abort(abort)
  );

  always #2.5 clk = ~clk;

  // crystal strobe generator
  initial begin
    forever begin
      @(posedge clk); #1;
      phase = (phase + 1 >= xp) ? 0 : phase + 1;
      xtal_stb = (phase == 0);
    end
  end

  // output monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tick) begin
      gap = cyc - last_tick;
      last_tick = cyc;
      ntick = ntick + 1;
    end
    if (abort) naborts = naborts + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output int v);
    @(posedge clk); #1;
    reg_sel = sel;
    @(posedge clk);
    @(negedge clk); #1;
    v = int'(reg_rdata);
  endtask

  task automatic wait_tick();
    int n0 = ntick;
    do begin @(negedge clk); #1; end while (ntick == n0);
  endtask

  task automatic set_div(input int d);
    wr(1'b0, 8'(d >> 8));
    wr(1'b1, 8'(d & 255));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int mark;
    int a0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    if (tick !== 1'b0) begin errors++; $display("FAIL R4 reset tick actual 1 expected 0"); end
    checks++;

    // R3: reset loads the shadow word; R1/R2 readback
    rd(1'b0, v); check("R3 R1 hi after reset", v, 1);
    rd(1'b1, v); check("R3 R2 lo after reset", v, 8'h2C);
    wait_tick(); wait_tick();
    check("R3 period from shadow", gap, 301);

    // R4: table of divisors and strobe spacings
    for (int i = 0; i < 6; i++) begin
      xp = VEC[i][1];
      set_div(VEC[i][0]);
      wait_tick(); wait_tick(); wait_tick();
      check("R4 tick spacing", gap, VEC[i][2]);
    end
    xp = 1;

    // R1: upper byte padding
    wr(1'b0, 8'hFF);
    rd(1'b0, v); check("R1 hi padded", v, 3);
    rd(1'b1, v); check("R2 lo readback", v, 0);

    // R6: change mid-period
    set_div(50);
    wait_tick(); wait_tick(); wait_tick();
    wr(1'b1, 8'd4);
    wait_tick(); check("R6 current period kept", gap, 51);
    wait_tick(); check("R6 new period applied", gap, 5);

    // R5/R7/R8: enter limp-home
    set_div(9);
    wait_tick(); wait_tick();
    a0 = naborts;
    @(posedge clk); #1 limp = 1'b1;
    @(negedge clk); #1 mark = cyc;
    wait_tick();
    check("R8 restart on entry", last_tick - mark, 37);
    check("R7 one abort on entry", naborts - a0, 1);
    wait_tick(); check("R5 limp period", gap, 36);
    wr(1'b1, 8'd3);
    wait_tick(); wait_tick();
    check("R5 registers ignored", gap, 36);
    rd(1'b1, v); check("R5 R2 write in limp stored", v, 3);

    // R8/R7: leave limp-home
    a0 = naborts;
    @(posedge clk); #1 limp = 1'b0;
    @(negedge clk); #1 mark = cyc;
    wait_tick();
    check("R8 restart on exit", last_tick - mark, 5);
    wait_tick(); check("R4 normal after exit", gap, 4);
    check("R7 no abort on exit", naborts - a0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule